// File: doc/BRIEF.md
# Reloading Down-Counter Timer

A register-mapped countdown timer for a chip's peripheral bus. Software writes a start value into a load register, then sets the enable bit in the control register. Setting the enable bit copies the start value into the counter. After that, the counter steps down by one on each cycle in which the selected tick-enable input is high. Two tick-enable inputs come from dividers outside the block, one fast and one slow, and a control bit picks between them.

When a tick arrives while the count is zero, the counter underflows and a level interrupt is raised. In periodic mode the counter then refills from the load register. In free-running mode it wraps to all ones. The interrupt stays high until software writes any value to the clear register.

The counter width is a parameter, and instances at 16 and 32 bits are expected. The bus is a simple synchronous port with address, write enable, write data and combinational read data.

Top module: `tmr_top`

## Requirements
- R1: After reset the counter, the load register, the control register and the interrupt output are all zero.
- R2: A write to the control register at byte offset 0x8 that takes bit 7 (enable) from 0 to 1 copies the load register into the counter at that clock edge. No decrement happens at that edge.
- R3: While enable is set, each cycle with the selected tick high lowers the count by one. While enable is clear the count holds. Counting in a cycle follows the control value held before any write in that same cycle.
- R4: Control bit 3 set selects `tick_fast_i`. Bit 3 clear selects `tick_slow_i`. The input that is not selected has no effect on the count.
- R5: With control bit 6 set (periodic), a selected tick at count zero reloads the counter from the load register and sets the interrupt.
- R6: With control bit 6 clear (free-running), a selected tick at count zero wraps the counter to all ones for the counter width and sets the interrupt.
- R7: A write of any data value to offset 0xC clears the interrupt. Without such a write, a set interrupt stays set.
- R8: If an underflow and a write to offset 0xC occur in the same cycle, the interrupt remains set.
- R9: A read at offset 0x4 returns the live count, zero-extended to 32 bits. Writes to offset 0x4 change nothing.
- R10: The load register at offset 0x0 reads back its value truncated to the counter width. The control register reads back only bits 7, 6 and 3, and every other bit reads as zero. Any other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_fast_i | input | 1 | Fast tick enable, used when control bit 3 is set |
| tick_slow_i | input | 1 | Slow tick enable, used when control bit 3 is clear |
| addr_i | input | ADDR_W | Byte address of the register |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Level interrupt, set on underflow |

## Verification
Some behaviour is checked by assertions on every clock. These cover:
- the enable-rise load;
- single-step decrement and hold when idle;
- reload and wrap at zero;
- setting, holding and clearing of the interrupt, including the case where underflow wins over clear;
- writes to the value register leaving the other registers unchanged.

Other behaviour can only be shown by the bench's scenarios. These are:
- the choice between the fast and slow tick;
- the exact read-back masks;
- the 16-bit and 32-bit wrap values;
- the rule that a write to the control register acts only from the next cycle.

Two instances, one of each width, are driven in lockstep against a model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;

  localparam logic [3:0] OFF_LOAD = 4'h0;
  localparam logic [3:0] OFF_VAL  = 4'h4;
  localparam logic [3:0] OFF_CTRL = 4'h8;
  localparam logic [3:0] OFF_CLR  = 4'hC;

  localparam int BIT_EN   = 7;
  localparam int BIT_PER  = 6;
  localparam int BIT_FAST = 3;

  typedef struct packed {
    logic en;
    logic per;
    logic fast;
  } ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  load_o,
  output logic              load_now_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic sel_load, sel_val, sel_ctrl, sel_clr;
  logic wr_load, wr_val, wr_ctrl;
  logic [CNT_W-1:0] load_q;
  ctrl_t ctrl_q;

  assign sel_load = (addr_i == ADDR_W'(OFF_LOAD));
  assign sel_val  = (addr_i == ADDR_W'(OFF_VAL));
  assign sel_ctrl = (addr_i == ADDR_W'(OFF_CTRL));
  assign sel_clr  = (addr_i == ADDR_W'(OFF_CLR));

  assign wr_load = we_i & sel_load;
  assign wr_val  = we_i & sel_val;
  assign wr_ctrl = we_i & sel_ctrl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_load) load_q <= wdata_i[CNT_W-1:0];
      if (wr_ctrl) begin
        ctrl_q.en   <= wdata_i[BIT_EN];
        ctrl_q.per  <= wdata_i[BIT_PER];
        ctrl_q.fast <= wdata_i[BIT_FAST];
      end
    end
  end

  assign ctrl_o     = ctrl_q;
  assign load_o     = load_q;
  assign load_now_o = wr_ctrl & wdata_i[BIT_EN] & ~ctrl_q.en;
  assign clr_o      = we_i & sel_clr;

  always_comb begin
    rdata_o = '0;
    if (sel_load) begin
      rdata_o = DATA_W'(load_q);
    end else if (sel_val) begin
      rdata_o = DATA_W'(cnt_i);
    end else if (sel_ctrl) begin
      rdata_o[BIT_EN]   = ctrl_q.en;
      rdata_o[BIT_PER]  = ctrl_q.per;
      rdata_o[BIT_FAST] = ctrl_q.fast;
    end
  end

  // R9
  val_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_val |=> ($stable(load_q) && $stable(ctrl_q)));
endmodule

// File: rtl/tmr_count.sv
module tmr_count
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ctrl_t            ctrl_i,
  input  logic [CNT_W-1:0] load_i,
  input  logic             load_now_i,
  input  logic             tick_fast_i,
  input  logic             tick_slow_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic tick, step, at_zero;

  assign tick    = ctrl_i.fast ? tick_fast_i : tick_slow_i;
  assign step    = ctrl_i.en & tick & ~load_now_i;
  assign at_zero = (cnt_q == '0);
  assign uf_o    = step & at_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_now_i) begin
      cnt_q <= load_i;
    end else if (step) begin
      if (at_zero) cnt_q <= ctrl_i.per ? load_i : '1;
      else         cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // R2
  enable_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_now_i |=> cnt_q == $past(load_i));
  // R3
  dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.en && !load_now_i) |=> $stable(cnt_q));
  // R5
  reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_o && ctrl_i.per) |=> cnt_q == $past(load_i));
  // R6
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_o && !ctrl_i.per) |=> (&cnt_q));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uf_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (uf_i)  irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;

  // R5
  set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_i |=> irq_q);
  // R7
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !uf_i) |=> !irq_q);
  // R7
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr_i) |=> irq_q);
  // R8
  uf_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uf_i && clr_i) |=> irq_q);
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_fast_i,
  input  logic              tick_slow_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o
);
  ctrl_t ctrl;
  logic [CNT_W-1:0] load, cnt;
  logic load_now, clr, uf;

  tmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .we_i       (we_i),
    .wdata_i    (wdata_i),
    .cnt_i      (cnt),
    .ctrl_o     (ctrl),
    .load_o     (load),
    .load_now_o (load_now),
    .clr_o      (clr),
    .rdata_o    (rdata_o)
  );

  tmr_count #(.CNT_W(CNT_W)) u_count (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_i      (ctrl),
    .load_i      (load),
    .load_now_i  (load_now),
    .tick_fast_i (tick_fast_i),
    .tick_slow_i (tick_slow_i),
    .cnt_o       (cnt),
    .uf_o        (uf)
  );

  tmr_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .uf_i   (uf),
    .clr_i  (clr),
    .irq_o  (irq_o)
  );
endmodule

// File: tb/tb_tmr_top.sv
`timescale 1ns/1ps
module tb_tmr_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic tf = 1'b0, ts = 1'b0;
  logic [31:0] rd16, rd32;
  logic irq16, irq32;

  int n_chk = 0;
  int n_fail = 0;

  logic [31:0] m_cnt [2];
  logic [31:0] m_load [2];
  logic        m_irq [2];
  logic [7:0]  m_ctrl;

  always #10 clk = ~clk;

  tmr_top #(.CNT_W(16), .ADDR_W(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_fast_i(tf), .tick_slow_i(ts),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rd16), .irq_o(irq16));

  tmr_top #(.CNT_W(32), .ADDR_W(4)) dut32 (
    .clk_i(clk), .rst_ni(rst_n), .tick_fast_i(tf), .tick_slow_i(ts),
    .addr_i(addr), .we_i(we), .wdata_i(wdata), .rdata_o(rd32), .irq_o(irq32));

  function automatic logic [31:0] mask(int i);
    return (i == 0) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Model of R2..R8 and R10, updated at each clock edge
  task automatic model_step(logic w, logic [3:0] a, logic [31:0] d, logic f, logic s);
    logic er, tk, uf;
    er = w && a == 4'h8 && d[7] && !m_ctrl[7];
    tk = m_ctrl[3] ? f : s;
    for (int i = 0; i < 2; i++) begin
      uf = 1'b0;
      if (er) m_cnt[i] = m_load[i];
      else if (m_ctrl[7] && tk) begin
        if (m_cnt[i] == 0) begin
          uf = 1'b1;
          m_cnt[i] = m_ctrl[6] ? m_load[i] : mask(i);
        end else m_cnt[i] = m_cnt[i] - 1;
      end
      if (uf) m_irq[i] = 1'b1;
      else if (w && a == 4'hC) m_irq[i] = 1'b0;
      if (w && a == 4'h0) m_load[i] = d & mask(i);
    end
    if (w && a == 4'h8) m_ctrl = d[7:0] & 8'hC8;
  endtask

  task automatic chk_all(string tag);
    addr = 4'h4;
    #1;
    chk({tag, " val16"}, rd16, m_cnt[0]);
    chk({tag, " val32"}, rd32, m_cnt[1]);
    chk({tag, " irq16"}, {31'd0, irq16}, {31'd0, m_irq[0]});
    chk({tag, " irq32"}, {31'd0, irq32}, {31'd0, m_irq[1]});
  endtask

  task automatic cyc(string tag, logic w, logic [3:0] a, logic [31:0] d, logic f, logic s);
    we = w; addr = a; wdata = d; tf = f; ts = s;
    @(posedge clk);
    model_step(w, a, d, f, s);
    @(negedge clk);
    we = 1'b0; tf = 1'b0; ts = 1'b0;
    chk_all(tag);
  endtask

  task automatic rd(logic [3:0] a);
    addr = a;
    #1;
  endtask

  initial begin
    for (int i = 0; i < 2; i++) begin
      m_cnt[i] = '0; m_load[i] = '0; m_irq[i] = 1'b0;
    end
    m_ctrl = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h0); chk("R1 load16", rd16, 0); chk("R1 load32", rd32, 0);
    rd(4'h8); chk("R1 ctrl16", rd16, 0); chk("R1 ctrl32", rd32, 0);
    chk_all("R1");

    // R10 load truncation, ctrl mask, unmapped address
    cyc("R10 load", 1, 4'h0, 32'h0003_0005, 0, 0);
    rd(4'h0); chk("R10 load16", rd16, 32'h5); chk("R10 load32", rd32, 32'h0003_0005);
    cyc("R10 load", 1, 4'h0, 32'h5, 0, 0);
    // R2 enable rise loads counter, periodic + fast
    cyc("R2", 1, 4'h8, 32'hFF, 1, 1);
    rd(4'h8); chk("R10 ctrl", rd16, 32'hC8);
    rd(4'h2); chk("R10 unmapped", rd32, 0);
    rd(4'h4); chk("R2 val", rd16, 32'h5);
    // R4 slow tick ignored with fast selected
    cyc("R4", 0, 4'h0, 0, 0, 1);
    rd(4'h4); chk("R4 val", rd32, 32'h5);
    // R3 decrement to zero
    for (int k = 0; k < 5; k++) cyc("R3", 0, 4'h0, 0, 1, 0);
    rd(4'h4); chk("R3 zero", rd16, 0);
    // R5 periodic reload and interrupt
    cyc("R5", 0, 4'h0, 0, 1, 0);
    rd(4'h4); chk("R5 reload", rd16, 32'h5); chk("R5 irq", {31'd0, irq32}, 1);
    // R7 clear with arbitrary data
    cyc("R7", 1, 4'hC, 32'h1234_5678, 0, 0);
    chk("R7 irq", {31'd0, irq16}, 0);
    // R9 write to value ignored
    cyc("R9", 1, 4'h4, 32'hAAAA_AAAA, 0, 0);
    rd(4'h4); chk("R9 val", rd32, 32'h5);
    // R6 free-running, slow tick; enable stays set, so no reload
    cyc("R6 ctrl", 1, 4'h8, 32'h80, 0, 0);
    for (int k = 0; k < 5; k++) cyc("R6", 0, 4'h0, 0, 0, 1);
    // R8 underflow and clear in the same cycle
    cyc("R8", 1, 4'hC, 32'h0, 0, 1);
    chk("R8 irq16", {31'd0, irq16}, 1);
    rd(4'h4); chk("R6 wrap16", rd16, 32'h0000_FFFF); chk("R6 wrap32", rd32, 32'hFFFF_FFFF);
    // R3 disabled counter holds
    cyc("R3 off", 1, 4'h8, 32'h0, 0, 0);
    for (int k = 0; k < 4; k++) cyc("R3 hold", 0, 4'h0, 0, 1, 1);
    rd(4'h4); chk("R3 hold", rd16, 32'h0000_FFFF);

    // Random mix, all requirements against the model
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      logic [31:0] d;
      r = $urandom % 16;
      d = ($urandom % 4 == 0) ? $urandom : ($urandom % 12);
      case (r)
        0, 1:    cyc("RND R5 R6 load", 1, 4'h0, d, $urandom % 2, $urandom % 2);
        2:       cyc("RND R2 R3 ctrl", 1, 4'h8, $urandom, $urandom % 2, $urandom % 2);
        3:       cyc("RND R7 R8 clr", 1, 4'hC, $urandom, $urandom % 2, $urandom % 2);
        4:       cyc("RND R9 wval", 1, 4'h4, $urandom, $urandom % 2, $urandom % 2);
        5:       cyc("RND R10 wother", 1, 4'($urandom % 16) | 4'h1, $urandom, $urandom % 2, $urandom % 2);
        default: cyc("RND R3 R4 tick", 0, 4'h0, 0, $urandom % 2, $urandom % 2);
      endcase
      if (n % 50 == 0) begin
        rd(4'h8); chk("RND R10 ctrl", rd16, {24'd0, m_ctrl});
        rd(4'h0); chk("RND R10 load", rd16, m_load[0]); chk("RND R10 load32", rd32, m_load[1]);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule